// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol engine of a serial memory that sits on a two-wire (I2C-style) bus. It samples the bus clock and data lines with a fast system clock, finds start and stop conditions, and takes in 8-bit words with the most significant bit first. The first word after a start is a device word. It is compared with three strap inputs, and the engine acknowledges it or stays silent. In later words the engine acknowledges received bytes or shifts read bytes out. The engine never drives the line high: `sdaOe` high means the pad pulls the data line low.

On its memory side the engine issues one request at a time over a valid/ready port. Each request carries a kind code, the three block bits and a data byte. Read data is taken from `rdData` in the cycle a read request is accepted. While the memory reports `memBusy` (for example during an internal program cycle), the engine refuses every device word, so a bus master can poll for completion.

The memory side is expected to accept each request within half an SCL period.

Top module: `twoWireMemSlave`

## Requirements
- R1: A start condition is a falling data line while the bus clock is high, and a stop is a rising data line while the bus clock is high. A start, including one inside any byte, restarts device-word reception. A stop returns the engine to idle. Both release the data line.
- R2: Words are 8 bits, MSB first, sampled on bus-clock rising edges. The engine acknowledges a word by pulling the data line low for the ninth clock. It drives the line at no other time except during its own read bits. `sdaOe` changes only after a detected bus-clock falling edge, never while the clock is high.
- R3: Device word layout, bit 7 down to bit 0: bit 7 is a constant 1; bits 6..4 are the select bits; bits 3..1 are the block bits, the upper three bits of the 11-bit memory address; bit 0 is the direction (1 = read). The select bits must equal `{strapSel[2], ~strapSel[1], strapSel[0]}`.
- R4: A device word that does not match is not acknowledged. It issues no request, and the engine ignores the bus, keeping the data line released, until the next start.
- R5: While `memBusy` is high, no device word is acknowledged and no request is issued. Once it is low, a matching device word is acknowledged again.
- R6: Request kinds (`reqKind`) are 0 = select, 1 = word address, 2 = write byte, 3 = read, 4 = stop.
  - An acknowledged device word issues kind 0 with `reqAddrHi` = block bits and `reqData` = {7'b0, direction}.
  - The first byte after a write-direction device word issues kind 1 with the byte.
  - Every later byte issues kind 2 with the byte.
  - A stop during a write transaction issues kind 4 with data 0.
  - A pending request holds its fields until accepted.
- R7: A read-direction device word issues kind 0 and then kind 3. Each master acknowledge after a read byte issues one more kind 3. The byte returned on acceptance is shifted out MSB first, with each bit changed after a bus-clock fall.
- R8: A master non-acknowledge after a read byte ends the read. The engine issues no further request and keeps the data line released through the following stop or start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line sample |
| sdaIn | input | 1 | Bus data line sample |
| sdaOe | output | 1 | 1 = pull the data line low |
| strapSel | input | 3 | Device select straps |
| memBusy | input | 1 | Memory internal operation in progress |
| reqValid | output | 1 | Memory-side request valid |
| reqReady | input | 1 | Memory-side request accepted |
| reqKind | output | 3 | Request kind code (R6) |
| reqAddrHi | output | 3 | Block bits from the last device word |
| reqData | output | 8 | Request data byte |
| rdData | input | 8 | Read byte, taken when a read request is accepted |

## Verification
The assertions check four things on every cycle:
- the pull-low output only rises in the cycle after a detected bus-clock fall;
- a waiting request keeps its kind and data;
- the ignore state never drives the line or raises a request;
- a device acknowledge never follows a busy sample.

The request order for write, random-read, sequential-read and current-address-read transfers can only be shown by the bench scenarios. The same holds for the returned read bytes, the effect of strap mismatches, a cleared fixed bit and busy polling, and recovery from a start inside a data byte.

// File: rtl/twoWirePkg.sv
package twoWirePkg;

  typedef enum logic [2:0] {
    REQ_SEL   = 3'd0,
    REQ_ADDR  = 3'd1,
    REQ_WRITE = 3'd2,
    REQ_READ  = 3'd3,
    REQ_STOP  = 3'd4
  } reqKindT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic clrBit;
    logic incBit;
    logic ackOn;
    logic sdaFree;
    logic txFirst;
    logic txShift;
    logic loadTx;
  } strobeT;

endpackage

// File: rtl/twoWireDatapath.sv
module twoWireDatapath
  import twoWirePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int CNT_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  strobeT            strb,
  input  logic [BYTE_W-1:0] txData,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaS,
  output logic [BYTE_W-1:0] rxByte,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              sdaOe
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sclPrev, sdaPrev;
  logic [BYTE_W-1:0] txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
      txReg  <= '0;
      sdaOe  <= 1'b0;
    end else begin
      if (strb.clrBit) bitCnt <= '0;
      else if (strb.incBit) bitCnt <= bitCnt + 1'b1;

      if (strb.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], sdaS};

      if (strb.loadTx) txReg <= txData;
      else if (strb.txShift) txReg <= {txReg[BYTE_W-2:0], 1'b0};

      if (strb.sdaFree) sdaOe <= 1'b0;
      else if (strb.ackOn) sdaOe <= 1'b1;
      else if (strb.txFirst) sdaOe <= ~txReg[BYTE_W-1];
      else if (strb.txShift) sdaOe <= ~txReg[BYTE_W-2];
    end
  end

endmodule

// File: rtl/twoWireCtrl.sv
module twoWireCtrl
  import twoWirePkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter int          CNT_W    = 4,
  parameter int          SEL_W    = 3,
  parameter int          HI_W     = 3,
  parameter logic [2:0]  INV_MASK = 3'b010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaS,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [SEL_W-1:0]  strapSel,
  input  logic              memBusy,
  input  logic              reqReady,
  output strobeT            strb,
  output stateT             state,
  output logic              reqValid,
  output reqKindT           reqKind,
  output logic [HI_W-1:0]   reqAddrHi,
  output logic [BYTE_W-1:0] reqData
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  stateT             stNext;
  logic              rwRead, rwNext, masterAck, ackNext;
  logic [HI_W-1:0]   blockHi, blockNext;
  logic              issue;
  reqKindT           issueKind;
  logic [BYTE_W-1:0] issueData;
  logic              devMatch;

  assign devMatch = rxByte[BYTE_W-1] &&
                    (rxByte[BYTE_W-2 -: SEL_W] == (strapSel ^ INV_MASK[SEL_W-1:0]));
  assign reqAddrHi = blockHi;

  always_comb begin
    stNext    = state;
    strb      = '0;
    issue     = 1'b0;
    issueKind = REQ_SEL;
    issueData = '0;
    rwNext    = rwRead;
    blockNext = blockHi;
    ackNext   = masterAck;
    strb.loadTx = reqValid && reqReady && (reqKind == REQ_READ);
    if (startDet) begin
      stNext       = ST_DEV;
      strb.clrBit  = 1'b1;
      strb.sdaFree = 1'b1;
    end else if (stopDet) begin
      stNext       = ST_IDLE;
      strb.clrBit  = 1'b1;
      strb.sdaFree = 1'b1;
      if (state == ST_WADDR || state == ST_WDATA) begin
        issue     = 1'b1;
        issueKind = REQ_STOP;
      end
    end else begin
      case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (sclRise) begin
            if (bitCnt < LAST_BIT) strb.shiftIn = 1'b1;
            if (bitCnt < ACK_BIT) strb.incBit = 1'b1;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            if (state == ST_DEV) begin
              if (devMatch && !memBusy) begin
                strb.ackOn = 1'b1;
                issue      = 1'b1;
                issueKind  = REQ_SEL;
                issueData  = BYTE_W'(rxByte[0]);
                rwNext     = rxByte[0];
                blockNext  = rxByte[HI_W:1];
              end else begin
                stNext = ST_IGNORE;
              end
            end else begin
              strb.ackOn = 1'b1;
              issue      = 1'b1;
              issueKind  = (state == ST_WADDR) ? REQ_ADDR : REQ_WRITE;
              issueData  = rxByte;
            end
          end else if (sclFall && bitCnt == ACK_BIT) begin
            strb.clrBit = 1'b1;
            if (state == ST_DEV && rwRead) begin
              stNext       = ST_RDATA;
              strb.txFirst = 1'b1;
            end else begin
              strb.sdaFree = 1'b1;
              if (state == ST_DEV) stNext = ST_WADDR;
              else stNext = ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            if (bitCnt < ACK_BIT) strb.incBit = 1'b1;
            if (bitCnt == LAST_BIT) begin
              ackNext = !sdaS;
              if (!sdaS) begin
                issue     = 1'b1;
                issueKind = REQ_READ;
              end
            end
          end else if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              strb.sdaFree = 1'b1;
            end else if (bitCnt == ACK_BIT) begin
              strb.clrBit = 1'b1;
              if (masterAck) strb.txFirst = 1'b1;
              else stNext = ST_IGNORE;
            end else if (bitCnt != '0) begin
              strb.txShift = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rwRead    <= 1'b0;
      blockHi   <= '0;
      masterAck <= 1'b0;
      reqValid  <= 1'b0;
      reqKind   <= REQ_SEL;
      reqData   <= '0;
    end else begin
      state     <= stNext;
      rwRead    <= rwNext;
      blockHi   <= blockNext;
      masterAck <= ackNext;
      if (issue) begin
        reqValid <= 1'b1;
        reqKind  <= issueKind;
        reqData  <= issueData;
      end else if (reqValid && reqReady) begin
        if (reqKind == REQ_SEL && rwRead) begin
          reqKind <= REQ_READ;
          reqData <= '0;
        end else begin
          reqValid <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/twoWireMemSlave.sv
module twoWireMemSlave
  import twoWirePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int SEL_W       = 3,
  parameter int HI_W        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [SEL_W-1:0]  strapSel,
  input  logic              memBusy,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [2:0]        reqKind,
  output logic [HI_W-1:0]   reqAddrHi,
  output logic [BYTE_W-1:0] reqData,
  input  logic [BYTE_W-1:0] rdData
);

  localparam int CNT_W = $clog2(BYTE_W + 2);

  strobeT            strb;
  stateT             ctrlState;
  reqKindT           kindW;
  logic              sclRiseW, sclFallW, startW, stopW, sdaSW;
  logic [BYTE_W-1:0] rxByteW;
  logic [CNT_W-1:0]  bitCntW;
  logic              stateIsDev, stateIsIgnore;

  twoWireDatapath #(
    .SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .txData(rdData), .sclRise(sclRiseW), .sclFall(sclFallW),
    .startDet(startW), .stopDet(stopW), .sdaS(sdaSW), .rxByte(rxByteW),
    .bitCnt(bitCntW), .sdaOe(sdaOe)
  );

  twoWireCtrl #(
    .BYTE_W(BYTE_W), .CNT_W(CNT_W), .SEL_W(SEL_W), .HI_W(HI_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRiseW), .sclFall(sclFallW),
    .startDet(startW), .stopDet(stopW), .sdaS(sdaSW), .rxByte(rxByteW),
    .bitCnt(bitCntW), .strapSel(strapSel), .memBusy(memBusy),
    .reqReady(reqReady), .strb(strb), .state(ctrlState),
    .reqValid(reqValid), .reqKind(kindW), .reqAddrHi(reqAddrHi),
    .reqData(reqData)
  );

  assign reqKind       = kindW;
  assign stateIsDev    = (ctrlState == ST_DEV);
  assign stateIsIgnore = (ctrlState == ST_IGNORE);

endmodule

// File: rtl/twoWireChecker.sv
module twoWireChecker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic              sclFall,
  input logic              reqValid,
  input logic              reqReady,
  input logic [2:0]        reqKind,
  input logic [BYTE_W-1:0] reqData,
  input logic              memBusy,
  input logic              stateIsDev,
  input logic              stateIsIgnore
);

  // R2
  pull_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(sclFall));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqKind) && $stable(reqData));

  // R4
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateIsIgnore |-> !sdaOe && !$rose(reqValid));

  // R5
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) && stateIsDev |-> !$past(memBusy));

endmodule

bind twoWireMemSlave twoWireChecker #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclFall(sclFallW),
  .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind),
  .reqData(reqData), .memBusy(memBusy), .stateIsDev(stateIsDev),
  .stateIsIgnore(stateIsIgnore)
);

// File: tb/twoWireMemSlave_tb.sv
module twoWireMemSlave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 8;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaOe, sdaBus;
  logic [2:0] strapSel = 3'b011;
  logic memBusy = 1'b0;
  logic reqValid, reqReady;
  logic [2:0] reqKind, reqAddrHi;
  logic [7:0] reqData, rdData;

  int checks = 0, errors = 0, highChanges = 0;
  logic prevOe = 1'b0;
  int logQ[$];

  logic [7:0]  mem [0:2047];
  logic [10:0] ptr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaBus   = sdaDrv & ~sdaOe;
  assign reqReady = 1'b1;
  assign rdData   = mem[ptr];

  twoWireMemSlave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .strapSel(strapSel), .memBusy(memBusy), .reqValid(reqValid),
    .reqReady(reqReady), .reqKind(reqKind), .reqAddrHi(reqAddrHi),
    .reqData(reqData), .rdData(rdData)
  );

  // behavioural memory and request log
  initial for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
  always @(posedge clk) begin
    if (rstN && reqValid) begin
      logQ.push_back(int'(reqKind) * 4096 + int'(reqAddrHi) * 256 + int'(reqData));
      case (reqKind)
        3'd1: ptr <= {reqAddrHi, reqData};
        3'd2: begin mem[ptr] <= reqData; ptr <= {ptr[10:4], ptr[3:0] + 4'd1}; end
        3'd3: ptr <= ptr + 11'd1;
        default: ;
      endcase
    end
  end

  // per-clock: pull-low output must not change while bus clock is high (R2)
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rstN && sclDrv && sdaOe !== prevOe) highChanges++;
    prevOe = sdaOe;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int code(input int k, input int hi, input int d);
    return k * 4096 + hi * 256 + d;
  endfunction

  function automatic logic [7:0] devWord(input logic [2:0] blk, input logic rd);
    return {1'b1, strapSel ^ 3'b010, blk, rd};
  endfunction

  task automatic quarter();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; quarter();
    sclDrv = 1'b1; quarter();
    sdaDrv = 1'b0; quarter();
    sclDrv = 1'b0; quarter();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; quarter();
    sclDrv = 1'b1; quarter();
    sdaDrv = 1'b1; quarter();
  endtask

  task automatic bitCycle(input logic b, output logic seen, output logic oeSeen);
    sdaDrv = b; quarter();
    sclDrv = 1'b1; quarter();
    seen = sdaBus; oeSeen = sdaOe; quarter();
    sclDrv = 1'b0; quarter();
  endtask

  task automatic writeByte(input logic [7:0] v, output logic acked);
    logic s, o;
    int driven = 0;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(v[i], s, o);
      if (o) driven++;
    end
    check(driven == 0, "R2", "slave quiet during master bits", driven, 0);
    bitCycle(1'b1, s, o);
    acked = !s;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] v);
    logic s, o;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, s, o);
      v[i] = s;
    end
    bitCycle(!giveAck, s, o);
    check(o == 1'b0, "R8", "released during master ack bit", int'(o), 0);
  endtask

  task automatic expectLog(input int exp[$], input string req);
    check(logQ.size() == exp.size(), req, "request count", logQ.size(), exp.size());
    for (int i = 0; i < exp.size() && i < logQ.size(); i++)
      check(logQ[i] == exp[i], req, "request entry", logQ[i], exp[i]);
    logQ.delete();
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ak;
    logic [7:0] rv;
    int exp[$];

    repeat (5) @(negedge clk);
    check(sdaOe == 1'b0, "R2", "reset pull-low", int'(sdaOe), 0);
    check(reqValid == 1'b0, "R6", "reset request valid", int'(reqValid), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R3 R6: byte write, block 3 address 0x25
    busStart();
    writeByte(devWord(3'd3, 1'b0), ak); check(ak, "R3", "device ack", int'(ak), 1);
    writeByte(8'h25, ak); check(ak, "R2", "address ack", int'(ak), 1);
    writeByte(8'hA5, ak); check(ak, "R2", "data ack", int'(ak), 1);
    busStop(); quarter();
    exp = '{code(0,3,0), code(1,3,8'h25), code(2,3,8'hA5), code(4,3,0)};
    expectLog(exp, "R6");

    // R6: four-byte write from 0x2C
    busStart();
    writeByte(devWord(3'd3, 1'b0), ak);
    writeByte(8'h2C, ak);
    writeByte(8'h11, ak); writeByte(8'h22, ak);
    writeByte(8'h33, ak); writeByte(8'h44, ak);
    check(ak, "R6", "last write ack", int'(ak), 1);
    busStop(); quarter();
    logQ.delete();

    // R7: random read with sequential continuation
    busStart();
    writeByte(devWord(3'd3, 1'b0), ak);
    writeByte(8'h2C, ak);
    busStart();
    writeByte(devWord(3'd3, 1'b1), ak); check(ak, "R7", "read device ack", int'(ak), 1);
    readByte(1'b1, rv); check(rv == 8'h11, "R7", "read byte 0", rv, 8'h11);
    readByte(1'b1, rv); check(rv == 8'h22, "R7", "read byte 1", rv, 8'h22);
    readByte(1'b0, rv); check(rv == 8'h33, "R7", "read byte 2", rv, 8'h33);
    busStop(); quarter();
    exp = '{code(0,3,0), code(1,3,8'h2C), code(0,3,1), code(3,3,0), code(3,3,0), code(3,3,0)};
    expectLog(exp, "R7");

    // R7: current address read continues at 0x2F
    busStart();
    writeByte(devWord(3'd3, 1'b1), ak);
    readByte(1'b0, rv); check(rv == 8'h44, "R7", "current read", rv, 8'h44);
    busStop(); quarter();
    exp = '{code(0,3,1), code(3,3,0)};
    expectLog(exp, "R8");

    // R4: select mismatch, then cleared fixed bit
    busStart();
    writeByte({1'b1, 3'b011, 3'd3, 1'b0}, ak); check(!ak, "R4", "mismatch nack", int'(ak), 0);
    writeByte(8'h55, ak); check(!ak, "R4", "ignored byte nack", int'(ak), 0);
    busStop(); quarter();
    busStart();
    writeByte({1'b0, strapSel ^ 3'b010, 3'd3, 1'b0}, ak); check(!ak, "R4", "fixed bit nack", int'(ak), 0);
    busStop(); quarter();
    exp = '{};
    expectLog(exp, "R4");

    // R5: busy refuses, then accepts
    memBusy = 1'b1;
    busStart();
    writeByte(devWord(3'd2, 1'b0), ak); check(!ak, "R5", "busy nack", int'(ak), 0);
    busStop(); quarter();
    exp = '{};
    expectLog(exp, "R5");
    memBusy = 1'b0;
    busStart();
    writeByte(devWord(3'd2, 1'b0), ak); check(ak, "R5", "ack after busy", int'(ak), 1);
    busStop(); quarter();
    exp = '{code(0,2,0), code(4,2,0)};
    expectLog(exp, "R5");

    // R1: start inside a data byte restarts device reception
    busStart();
    writeByte(devWord(3'd1, 1'b0), ak);
    writeByte(8'h40, ak);
    begin
      logic s, o;
      bitCycle(1'b1, s, o); bitCycle(1'b0, s, o);
      bitCycle(1'b1, s, o); bitCycle(1'b1, s, o);
    end
    busStart();
    writeByte(devWord(3'd1, 1'b0), ak); check(ak, "R1", "ack after restart", int'(ak), 1);
    writeByte(8'h41, ak);
    writeByte(8'h5A, ak);
    busStop(); quarter();
    exp = '{code(0,1,0), code(1,1,8'h40), code(0,1,0), code(1,1,8'h41),
            code(2,1,8'h5A), code(4,1,0)};
    expectLog(exp, "R1");
    busStart();
    writeByte(devWord(3'd1, 1'b0), ak);
    writeByte(8'h40, ak);
    busStart();
    writeByte(devWord(3'd1, 1'b1), ak);
    readByte(1'b1, rv); check(rv == 8'h00, "R1", "partial byte not stored", rv, 0);
    readByte(1'b0, rv); check(rv == 8'h5A, "R1", "restarted write stored", rv, 8'h5A);
    busStop(); quarter();
    check(sdaOe == 1'b0, "R8", "released after stop", int'(sdaOe), 0);

    check(highChanges == 0, "R2", "changes while clock high", highChanges, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule